// File: doc/BRIEF.md
# Synchronized Three-Channel Counter Group

This block holds a group of up-counters, three by default, each 16 bits wide. A shared start vector gates them, with one bit per channel. A channel advances by one on each cycle in which its start bit and its count-enable tick are both high. Prescaling and compare or capture logic sit outside the block. Each channel has a write port for presetting its counter and a clear request.

A synchronization vector places channels in a common group. A write to any member of the group loads the written value into every member in the same cycle. A clear on any member zeroes the whole group. Channels outside the group respond only to their own write and clear inputs.

A cascade-enable input joins channel 1 and channel 2 into one 32-bit counter. Channel 2 is the lower half and counts on its own tick. Channel 1 is the upper half and advances only when channel 2 wraps by counting. The 32-bit value is always available on its own output.

Top module: `sync_timer_group`

## Requirements
- R1: While `rst` is high at a rising clock edge, every counter is set to 0. The reset is synchronous and active high.
- R2: Channel i counts only when both `start_i[i]` and `tick_i[i]` are 1, and it then increments by one on that edge. In every other case its value holds. From 0xFFFF it wraps to 0x0000.
- R3: A write (`wr_en_i[i]`=1) to a channel whose `sync_en_i` bit is 1 loads the data into every channel whose `sync_en_i` bit is 1, all on the same edge. When several synchronized channels write in the same cycle, the data of the lowest-numbered writer is used.
- R4: A clear request on a channel whose `sync_en_i` bit is 1 sets every synchronized counter to 0 on the same edge.
- R5: A channel whose `sync_en_i` bit is 0 is unaffected by writes and clears on other channels. It loads only its own write data and clears only on its own request.
- R6: With `casc_en_i`=1, channel 1 increments exactly when channel 2 counts from 0xFFFF to 0x0000. Channel 1's own tick and start bit then have no effect. `wide_o` is always {channel 1, channel 2}, with channel 1 in bits 31:16.
- R7: A write that applies to a channel takes priority over a count in the same cycle. The counter takes the written value and does not add one to it.
- R8: A clear that applies to a channel takes priority over a write in the same cycle. The counter becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 3 | Per-channel run enable |
| sync_en_i | input | 3 | Per-channel membership in the synchronized group |
| tick_i | input | 3 | Per-channel count-enable tick |
| wr_en_i | input | 3 | Per-channel counter write strobe |
| wr_data_i | input | 3x16 | Per-channel write data, packed, with channel i in element i |
| clr_i | input | 3 | Per-channel clear request |
| casc_en_i | input | 1 | Joins channels 1 (upper) and 2 (lower) into a 32-bit counter |
| cnt_o | output | 3x16 | Counter values, with channel i in element i |
| wide_o | output | 32 | Combined value {channel 1, channel 2} |

## Verification
The assertions check on every cycle the following: each counter increments or holds correctly, members of the group end equal after a group write, and a group clear zeroes all members. They also check that clear wins over write and write wins over count, and that in cascade mode the upper half moves only on a lower-half wrap. Other behaviours depend on specific data values and need the bench's scenarios to show them. These are lowest-index selection among simultaneous group writers, isolation of channels outside the group during other channels' writes and clears, and the exact 32-bit carry sequence. The bench compares every channel and the wide output each cycle against its own model.

// File: rtl/tmr_grp_pkg.sv
`timescale 1ns/1ps
package tmr_grp_pkg;

    localparam int unsigned DEF_NCH = 3;
    localparam int unsigned DEF_CW  = 16;
    // cascade pairing: upper half and lower half channel indices
    localparam int unsigned CASC_HI = 1;
    localparam int unsigned CASC_LO = 2;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_COUNT = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_CLEAR = 2'd3
    } act_e;

    typedef struct packed {
        logic clr;   // some synchronized channel requests a clear
        logic ld;    // some synchronized channel is written
    } grp_req_t;

    // clear beats load, load beats count
    function automatic act_e pick_act(input logic clr, input logic ld, input logic inc);
        if (clr)      return ACT_CLEAR;
        else if (ld)  return ACT_LOAD;
        else if (inc) return ACT_COUNT;
        else          return ACT_HOLD;
    endfunction

endpackage

// File: rtl/tmr_sync_ctrl.sv
`timescale 1ns/1ps
module tmr_sync_ctrl
    import tmr_grp_pkg::*;
#(
    parameter int unsigned NCH = DEF_NCH,
    parameter int unsigned CW  = DEF_CW
) (
    input  logic [NCH-1:0]         sync_en_i,
    input  logic [NCH-1:0]         wr_en_i,
    input  logic [NCH-1:0][CW-1:0] wr_data_i,
    input  logic [NCH-1:0]         clr_i,
    output grp_req_t               req_o,
    output logic [CW-1:0]          data_o
);

    logic [NCH-1:0] wr_grp;
    logic [NCH-1:0] clr_grp;

    assign wr_grp  = wr_en_i & sync_en_i;
    assign clr_grp = clr_i & sync_en_i;

    always_comb begin
        req_o.clr = |clr_grp;
        req_o.ld  = |wr_grp;
        data_o    = '0;
        // walk downward so the lowest-numbered writer is the last to set it
        for (int i = NCH - 1; i >= 0; i--) begin
            if (wr_grp[i]) data_o = wr_data_i[i];
        end
    end

endmodule

// File: rtl/tmr_chan.sv
`timescale 1ns/1ps
module tmr_chan
    import tmr_grp_pkg::*;
#(
    parameter int unsigned CW = DEF_CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          own_clr_i,
    input  logic          own_wr_i,
    input  logic [CW-1:0] own_data_i,
    input  logic          synced_i,
    input  grp_req_t      grp_i,
    input  logic [CW-1:0] grp_data_i,
    input  logic          inc_i,
    output logic [CW-1:0] cnt_o
);

    logic          clr_hit;
    logic          grp_ld_hit;
    logic          ld_hit;
    logic [CW-1:0] ld_val;
    act_e          act;
    logic [CW-1:0] cnt_q;

    assign clr_hit    = own_clr_i | (synced_i & grp_i.clr);
    assign grp_ld_hit = synced_i & grp_i.ld;
    assign ld_hit     = grp_ld_hit | own_wr_i;
    assign ld_val     = grp_ld_hit ? grp_data_i : own_data_i;
    assign act        = pick_act(clr_hit, ld_hit, inc_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case (act)
                ACT_CLEAR: cnt_q <= '0;
                ACT_LOAD:  cnt_q <= ld_val;
                ACT_COUNT: cnt_q <= cnt_q + CW'(1);
                default:   cnt_q <= cnt_q;
            endcase
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/sync_timer_group.sv
`timescale 1ns/1ps
module sync_timer_group
    import tmr_grp_pkg::*;
#(
    parameter int unsigned NCH = DEF_NCH,
    parameter int unsigned CW  = DEF_CW
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NCH-1:0]         start_i,
    input  logic [NCH-1:0]         sync_en_i,
    input  logic [NCH-1:0]         tick_i,
    input  logic [NCH-1:0]         wr_en_i,
    input  logic [NCH-1:0][CW-1:0] wr_data_i,
    input  logic [NCH-1:0]         clr_i,
    input  logic                   casc_en_i,
    output logic [NCH-1:0][CW-1:0] cnt_o,
    output logic [2*CW-1:0]        wide_o
);

    localparam bit HAS_CASC = (NCH > CASC_LO);

    grp_req_t       grp_req;
    logic [CW-1:0]  grp_data;
    logic [NCH-1:0] run;
    logic [NCH-1:0] inc;
    logic           lo_carry;

    assign run = start_i & tick_i;

    tmr_sync_ctrl #(.NCH(NCH), .CW(CW)) u_sync (
        .sync_en_i (sync_en_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .clr_i     (clr_i),
        .req_o     (grp_req),
        .data_o    (grp_data)
    );

    generate
        if (HAS_CASC) begin : g_casc
            logic lo_ovr;
            // lower half loses its count when a clear or load applies to it
            assign lo_ovr   = clr_i[CASC_LO] | wr_en_i[CASC_LO]
                            | (sync_en_i[CASC_LO] & (grp_req.clr | grp_req.ld));
            assign lo_carry = run[CASC_LO] & ~lo_ovr & (&cnt_o[CASC_LO]);

            always_comb begin
                inc = run;
                if (casc_en_i) inc[CASC_HI] = lo_carry;
            end

            assign wide_o = {cnt_o[CASC_HI], cnt_o[CASC_LO]};
        end else begin : g_flat
            logic unused_casc;
            assign unused_casc = casc_en_i;
            assign lo_carry    = 1'b0;
            assign inc         = run;
            assign wide_o      = '0;
        end
    endgenerate

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tmr_chan #(.CW(CW)) u_ch (
            .clk        (clk),
            .rst        (rst),
            .own_clr_i  (clr_i[i]),
            .own_wr_i   (wr_en_i[i]),
            .own_data_i (wr_data_i[i]),
            .synced_i   (sync_en_i[i]),
            .grp_i      (grp_req),
            .grp_data_i (grp_data),
            .inc_i      (inc[i]),
            .cnt_o      (cnt_o[i])
        );
    end

endmodule

// File: rtl/tmr_grp_chk.sv
`timescale 1ns/1ps
module tmr_grp_chk
    import tmr_grp_pkg::*;
#(
    parameter int unsigned NCH = DEF_NCH,
    parameter int unsigned CW  = DEF_CW
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NCH-1:0]         start_i,
    input logic [NCH-1:0]         sync_en_i,
    input logic [NCH-1:0]         tick_i,
    input logic [NCH-1:0]         wr_en_i,
    input logic [NCH-1:0][CW-1:0] wr_data_i,
    input logic [NCH-1:0]         clr_i,
    input logic                   casc_en_i,
    input logic [NCH-1:0][CW-1:0] cnt_o,
    input logic [2*CW-1:0]        wide_o
);

    logic [NCH-1:0] hit_clr;
    logic [NCH-1:0] hit_wr;
    logic           any_sclr;
    logic           any_swr;

    assign any_sclr = |(clr_i & sync_en_i);
    assign any_swr  = |(wr_en_i & sync_en_i);
    assign hit_clr  = clr_i   | (sync_en_i & {NCH{any_sclr}});
    assign hit_wr   = wr_en_i | (sync_en_i & {NCH{any_swr}});

    for (genvar i = 0; i < NCH; i++) begin : g_per
        localparam bit IS_HI = (i == CASC_HI) && (NCH > CASC_LO);
        logic solo;
        assign solo = !hit_clr[i] && !hit_wr[i] && !(IS_HI && casc_en_i);

        // R2: increment by one on start and tick
        a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
            solo && start_i[i] && tick_i[i] |=> cnt_o[i] == $past(cnt_o[i]) + CW'(1));

        // R2: hold when not running
        a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
            solo && !(start_i[i] && tick_i[i]) |=> $stable(cnt_o[i]));

        // R4 and R8: any applicable clear gives zero
        a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
            hit_clr[i] |=> cnt_o[i] == '0);

        // R7: own unsynchronized write beats count
        a_r7_write_over_tick: assert property (@(posedge clk) disable iff (rst)
            wr_en_i[i] && !sync_en_i[i] && !clr_i[i] |=> cnt_o[i] == $past(wr_data_i[i]));

        for (genvar j = i + 1; j < NCH; j++) begin : g_pair
            // R3: synchronized members agree after a group write
            a_r3_sync_equal: assert property (@(posedge clk) disable iff (rst)
                sync_en_i[i] && sync_en_i[j] && (any_swr || any_sclr)
                |=> cnt_o[i] == cnt_o[j]);
        end
    end

    if (NCH > CASC_LO) begin : g_casc_chk
        logic lo_wrap;
        logic hi_free;
        assign lo_wrap = start_i[CASC_LO] && tick_i[CASC_LO] && !hit_clr[CASC_LO]
                       && !hit_wr[CASC_LO] && (&cnt_o[CASC_LO]);
        assign hi_free = !hit_clr[CASC_HI] && !hit_wr[CASC_HI];

        // R6: upper half advances on the lower-half wrap
        a_r6_carry_up: assert property (@(posedge clk) disable iff (rst)
            casc_en_i && hi_free && lo_wrap
            |=> cnt_o[CASC_HI] == $past(cnt_o[CASC_HI]) + CW'(1) && cnt_o[CASC_LO] == '0);

        // R6: upper half ignores its own tick otherwise
        a_r6_hi_quiet: assert property (@(posedge clk) disable iff (rst)
            casc_en_i && hi_free && !lo_wrap |=> $stable(cnt_o[CASC_HI]));

        // R6: combined output layout
        a_r6_wide_map: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> wide_o[2*CW-1:CW] == $past(cnt_o[CASC_HI]) + CW'($past(casc_en_i && hi_free && lo_wrap))
                 || $past(!hi_free) || $past(!casc_en_i) || $past(!lo_wrap));
    end

endmodule

bind sync_timer_group tmr_grp_chk #(.NCH(NCH), .CW(CW)) u_chk (.*);

// File: tb/sync_timer_group_tb.sv
`timescale 1ns/1ps
module sync_timer_group_tb_top;

    localparam int NCH = 3;
    localparam int CW  = 16;

    logic                   clk = 1'b0;
    logic                   rst;
    logic [NCH-1:0]         start_i, sync_en_i, tick_i, wr_en_i, clr_i;
    logic [NCH-1:0][CW-1:0] wr_data_i;
    logic                   casc_en_i;
    logic [NCH-1:0][CW-1:0] cnt_o;
    logic [2*CW-1:0]        wide_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [2:0][15:0] exp_cnt;
    string tags [3];

    always #5 clk = ~clk;

    sync_timer_group dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .sync_en_i(sync_en_i),
        .tick_i(tick_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .clr_i(clr_i), .casc_en_i(casc_en_i), .cnt_o(cnt_o), .wide_o(wide_o)
    );

    // next-state model written from the requirements
    function automatic logic [2:0][15:0] model(
        input logic [2:0][15:0] cur, input logic [2:0] st, sy, tk, wr, cl,
        input logic cs, input logic [2:0][15:0] wd);
        logic [2:0][15:0] nx;
        logic gclr, gld, carry, lo_busy;
        logic [15:0] gdat;
        gclr = |(cl & sy);
        gld  = |(wr & sy);
        gdat = 16'h0;
        for (int k = 2; k >= 0; k--) if (wr[k] && sy[k]) gdat = wd[k];
        lo_busy = cl[2] || wr[2] || (sy[2] && (gclr || gld));
        carry = st[2] && tk[2] && !lo_busy && cur[2] == 16'hFFFF;
        for (int k = 0; k < 3; k++) begin
            logic run;
            run = (k == 1 && cs) ? carry : (st[k] && tk[k]);
            if (cl[k] || (sy[k] && gclr))  nx[k] = 16'h0;
            else if (sy[k] && gld)         nx[k] = gdat;
            else if (wr[k])                nx[k] = wd[k];
            else if (run)                  nx[k] = cur[k] + 16'h1;
            else                           nx[k] = cur[k];
        end
        return nx;
    endfunction

    function automatic string tag_of(input int k, input logic [2:0] st, sy, tk, wr, cl, input logic cs);
        if ((cl[k] || (sy[k] && |(cl & sy))) && (wr[k] || (sy[k] && |(wr & sy)))) return "R8";
        if (cl[k] || (sy[k] && |(cl & sy))) return "R4";
        if (sy[k] && |(wr & sy))            return "R3";
        if (wr[k] && st[k] && tk[k])        return "R7";
        if (wr[k])                          return "R5";
        if (k == 1 && cs)                   return "R6";
        if (!sy[k] && |(wr | cl))           return "R5";
        return "R2";
    endfunction

    task automatic compare(input string r0, r1, r2, input string rw);
        string rs [3];
        rs[0] = r0; rs[1] = r1; rs[2] = r2;
        for (int k = 0; k < 3; k++) begin
            n_chk++;
            if (cnt_o[k] !== exp_cnt[k]) begin
                n_fail++;
                $display("FAIL %s ch%0d actual=%h expected=%h", rs[k], k, cnt_o[k], exp_cnt[k]);
            end
        end
        n_chk++;
        if (wide_o !== {exp_cnt[1], exp_cnt[2]}) begin
            n_fail++;
            $display("FAIL %s wide actual=%h expected=%h", rw, wide_o, {exp_cnt[1], exp_cnt[2]});
        end
    endtask

    // called at a falling edge; applies inputs for one rising edge, checks at the next falling edge
    task automatic cyc(input logic [2:0] st, sy, tk, wr, cl, input logic cs,
                       input logic [2:0][15:0] wd);
        start_i = st; sync_en_i = sy; tick_i = tk; wr_en_i = wr; clr_i = cl;
        casc_en_i = cs; wr_data_i = wd;
        for (int k = 0; k < 3; k++) tags[k] = tag_of(k, st, sy, tk, wr, cl, cs);
        exp_cnt = model(exp_cnt, st, sy, tk, wr, cl, cs, wd);
        @(negedge clk);
        compare(tags[0], tags[1], tags[2], "R6");
    endtask

    function automatic logic [2:0][15:0] d3(input logic [15:0] a, b, c);
        return {c, b, a};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1'b1;
        start_i = '0; sync_en_i = '0; tick_i = '0; wr_en_i = '0; clr_i = '0;
        casc_en_i = 1'b0; wr_data_i = '0;
        exp_cnt = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        compare("R1", "R1", "R1", "R1");

        // R2: plain counting with all started
        repeat (5) cyc(3'b111, 3'b000, 3'b111, 3'b000, 3'b000, 1'b0, d3(0, 0, 0));
        // R2: tick without start holds
        cyc(3'b000, 3'b000, 3'b111, 3'b000, 3'b000, 1'b0, d3(0, 0, 0));
        // R7: write on ch0 along with a tick
        cyc(3'b111, 3'b000, 3'b111, 3'b001, 3'b000, 1'b0, d3(16'hFFFF, 0, 0));
        // R2: wrap 0xFFFF -> 0
        cyc(3'b001, 3'b000, 3'b001, 3'b000, 3'b000, 1'b0, d3(0, 0, 0));
        // R3 and R5: ch1 write in group {0,1}, ch2 outside the group
        cyc(3'b000, 3'b011, 3'b000, 3'b010, 3'b000, 1'b0, d3(0, 16'h1234, 0));
        // R3: two group writers, lowest index data wins
        cyc(3'b000, 3'b111, 3'b000, 3'b110, 3'b000, 1'b0, d3(0, 16'hAAAA, 16'h5555));
        // R5: unsynced ch2 gets its own value
        cyc(3'b000, 3'b000, 3'b000, 3'b100, 3'b000, 1'b0, d3(0, 0, 16'h0777));
        // R4 and R5: clear on ch0 in group {0,1}, ch2 keeps
        cyc(3'b000, 3'b011, 3'b000, 3'b000, 3'b001, 1'b0, d3(0, 0, 0));
        // R8: clear and write together on unsynced ch2
        cyc(3'b000, 3'b000, 3'b000, 3'b100, 3'b100, 1'b0, d3(0, 0, 16'hBEEF));
        // R6: cascade, ch1=0x0007, ch2=0xFFFE
        cyc(3'b000, 3'b000, 3'b000, 3'b110, 3'b000, 1'b1, d3(0, 16'h0007, 16'hFFFE));
        // R6: ch1 ticks alone are ignored
        repeat (3) cyc(3'b010, 3'b000, 3'b010, 3'b000, 3'b000, 1'b1, d3(0, 0, 0));
        // R6: ch2 steps to FFFF, then wraps and carries
        repeat (3) cyc(3'b110, 3'b000, 3'b110, 3'b000, 3'b000, 1'b1, d3(0, 0, 0));

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            logic [2:0] st, sy, tk, wr, cl;
            logic cs;
            logic [2:0][15:0] wd;
            cs = ((n / 200) % 2) == 1;
            for (int k = 0; k < 3; k++) begin
                st[k] = ($urandom % 8) != 0;
                sy[k] = ($urandom % 2) != 0;
                tk[k] = ($urandom % 4) != 0;
                wr[k] = ($urandom % 12) == 0;
                cl[k] = ($urandom % 24) == 0;
                case ($urandom % 4)
                    0:       wd[k] = 16'hFFFF - 16'($urandom % 4);
                    default: wd[k] = 16'($urandom);
                endcase
            end
            cyc(st, sy, tk, wr, cl, cs, wd);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule